// File: doc/BRIEF.md
# Event Timestamp Latch Bank

This block freezes the running 64-bit nanosecond time into a holding slot whenever the packet datapath flags a timing event. Receive events are steered into a small pool of receive slots. Transmit events use a single dedicated slot. A slot that holds a value is locked: later events cannot disturb it until software reads back its upper word, and that read also frees the slot. Event detection and the time counter are outside the block. Both arrive as inputs: a one-cycle strobe per event and the current time value.

For each receive event the block returns the number of the slot it used, one cycle later, with a valid flag. The datapath places that number in the packet descriptor, so software knows which slot to read. If every receive slot is locked, the event is not stamped and the valid flag stays low. Software reaches the block through a 32-bit register port. The port has a control register, two occupancy registers and the low and high words of every slot. A level interrupt reports a locked transmit stamp when its enable bit is set.

Top module: `ts_latch_bank`

## Requirements
- R1: After reset all slots are free. The control register reads 0, both occupancy registers read 0, `tx_irq` is 0 and `rx_idx_vld` is 0.
- R2: A receive strobe while at least one slot is free stores the `time_now` value present in that cycle into the lowest-numbered free slot. It also sets bit n of the receive occupancy register (address 1), where bit n belongs to slot n.
- R3: The cycle after a receive strobe, `rx_idx_vld` is 1 and `rx_idx` gives the slot number used, provided a slot was free. It is a single-cycle pulse.
- R4: A locked receive slot keeps its value unchanged while later receive events arrive.
- R5: Slot n's low word is at address 4+2n and its high word at 5+2n. Reading the low word leaves the slot locked. Reading the high word returns the stored upper 32 bits and frees the slot, which clears its occupancy bit.
- R6: A receive strobe while all slots are locked and none is being freed is dropped. `rx_idx_vld` stays 0 and no slot value or occupancy bit changes.
- R7: If a high-word read frees a slot in the same cycle as a receive strobe, the freed slot counts as free. The new time goes into it and its occupancy bit stays set.
- R8: A transmit strobe stores `time_now` into the transmit slot (low word at address 12, high word at 13, occupancy bit 0 at address 2), unless that slot is already locked. In that case the strobe is dropped. Reading the high word frees the slot.
- R9: `tx_irq` is high exactly while bit 0 of the control register (address 0) is 1 and the transmit slot is locked. It goes low in the cycle after the transmit high word is read.
- R10: Read data appears on `rd_data` in the cycle after `rd_en`. A write with `wr_en` at address 0 updates the control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TIME_W | Current nanosecond time |
| rx_evt | input | 1 | Receive timing event strobe |
| tx_evt | input | 1 | Transmit timing event strobe |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register read address |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read data |
| rx_idx | output | IDX_W | Slot number given to the last receive event |
| rx_idx_vld | output | 1 | Receive event was stamped |
| tx_irq | output | 1 | Transmit stamp interrupt level |

## Verification
The bench builds the block with its defaults: four receive slots, a 64-bit time and a registered read port. With four slots, all sixteen occupancy patterns can be swept. For each pattern the bench computes which slot the next event must take, including the fully locked case where the event is dropped. The time input advances by a step that carries into the high word, so every stored low and high word is distinct and a wrong slot or a stale capture shows up. Directed sequences cover a release and a capture in the same cycle, and the transmit slot with its interrupt enabled and disabled.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;
   localparam int unsigned CTRL_ADDR     = 0;
   localparam int unsigned RX_STAT_ADDR  = 1;
   localparam int unsigned TX_STAT_ADDR  = 2;
   localparam int unsigned SLOT_BASE     = 4;
   localparam int unsigned CTRL_IRQEN_B  = 0;

   function automatic int unsigned rx_lo_addr(input int unsigned n);
      return SLOT_BASE + 2 * n;
   endfunction

   function automatic int unsigned rx_hi_addr(input int unsigned n);
      return SLOT_BASE + 2 * n + 1;
   endfunction

   function automatic int unsigned tx_lo_addr(input int unsigned slots);
      return SLOT_BASE + 2 * slots;
   endfunction

   function automatic int unsigned tx_hi_addr(input int unsigned slots);
      return SLOT_BASE + 2 * slots + 1;
   endfunction

   function automatic int unsigned reg_count(input int unsigned slots);
      return SLOT_BASE + 2 * slots + 2;
   endfunction
endpackage

// File: rtl/ts_slot.sv
module ts_slot #(
   parameter int unsigned TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              rel,
   input  logic [TIME_W-1:0] time_in,
   output logic              occ,
   output logic [TIME_W-1:0] val
);
   // capture wins over release: a slot freed and refilled in one cycle stays locked
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ <= 1'b0;
         val <= '0;
      end else if (cap) begin
         occ <= 1'b1;
         val <= time_in;
      end else if (rel) begin
         occ <= 1'b0;
      end
   end
endmodule

// File: rtl/ts_alloc.sv
module ts_alloc #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     free_vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ts_regfile.sv
module ts_regfile
   import ts_latch_pkg::*;
#(
   parameter int unsigned TIME_W   = 64,
   parameter int unsigned REG_W    = 32,
   parameter int unsigned RX_SLOTS = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          RD_PIPE  = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [REG_W-1:0]                wr_data,
   input  logic [RX_SLOTS-1:0]             rx_occ,
   input  logic [RX_SLOTS-1:0][TIME_W-1:0] rx_val,
   input  logic                            tx_occ,
   input  logic [TIME_W-1:0]               tx_val,
   output logic [REG_W-1:0]                rd_data,
   output logic                            irq_en,
   output logic [RX_SLOTS-1:0]             rx_rel,
   output logic                            tx_rel
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_RXST  = ADDR_W'(RX_STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_TXST  = ADDR_W'(TX_STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_TX_LO = ADDR_W'(tx_lo_addr(RX_SLOTS));
   localparam logic [ADDR_W-1:0] A_TX_HI = ADDR_W'(tx_hi_addr(RX_SLOTS));

   logic [REG_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_en <= 1'b0;
      else if (wr_en && wr_addr == A_CTRL)
         irq_en <= wr_data[CTRL_IRQEN_B];
   end

   genvar g;
   generate
      for (g = 0; g < RX_SLOTS; g++) begin : g_rel
         assign rx_rel[g] = rd_en && (rd_addr == ADDR_W'(rx_hi_addr(g)));
      end
   endgenerate
   assign tx_rel = rd_en && (rd_addr == A_TX_HI);

   always_comb begin
      rd_mux = '0;
      if (rd_addr == A_CTRL)  rd_mux[CTRL_IRQEN_B] = irq_en;
      if (rd_addr == A_RXST)  rd_mux[RX_SLOTS-1:0] = rx_occ;
      if (rd_addr == A_TXST)  rd_mux[0] = tx_occ;
      if (rd_addr == A_TX_LO) rd_mux = tx_val[REG_W-1:0];
      if (rd_addr == A_TX_HI) rd_mux = tx_val[TIME_W-1:REG_W];
      for (int n = 0; n < RX_SLOTS; n++) begin
         if (rd_addr == ADDR_W'(rx_lo_addr(n))) rd_mux = rx_val[n][REG_W-1:0];
         if (rd_addr == ADDR_W'(rx_hi_addr(n))) rd_mux = rx_val[n][TIME_W-1:REG_W];
      end
   end

   generate
      if (RD_PIPE) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               rd_data <= '0;
            else if (rd_en)
               rd_data <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/ts_latch_bank.sv
module ts_latch_bank
   import ts_latch_pkg::*;
#(
   parameter int unsigned TIME_W   = 64,
   parameter int unsigned REG_W    = 32,
   parameter int unsigned RX_SLOTS = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          RD_PIPE  = 1'b1,
   localparam int unsigned IDX_W   = (RX_SLOTS > 1) ? $clog2(RX_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic              rx_evt,
   input  logic              tx_evt,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [IDX_W-1:0]  rx_idx,
   output logic              rx_idx_vld,
   output logic              tx_irq
);
   localparam int unsigned NREGS = reg_count(RX_SLOTS);

   generate
      if (RX_SLOTS < 1) begin : g_chk_slots
         $error("ts_latch_bank: RX_SLOTS must be at least 1");
      end
      if (TIME_W != 2 * REG_W) begin : g_chk_width
         $error("ts_latch_bank: TIME_W must be twice REG_W");
      end
      if (REG_W < RX_SLOTS) begin : g_chk_stat
         $error("ts_latch_bank: occupancy bits do not fit one register");
      end
      if ((2 ** ADDR_W) < NREGS) begin : g_chk_addr
         $error("ts_latch_bank: ADDR_W too small for register map");
      end
   endgenerate

   logic [RX_SLOTS-1:0]             rx_occ;
   logic [RX_SLOTS-1:0]             rx_rel;
   logic [RX_SLOTS-1:0]             rx_cap;
   logic [RX_SLOTS-1:0][TIME_W-1:0] rx_val;
   logic [RX_SLOTS-1:0]             rx_free;
   logic [IDX_W-1:0]                pick_idx;
   logic                            pick_any;
   logic                            tx_occ;
   logic                            tx_rel;
   logic                            tx_cap;
   logic [TIME_W-1:0]               tx_val;
   logic                            irq_en;

   // a slot being released this cycle is already free for a new event
   assign rx_free = ~rx_occ | rx_rel;

   ts_alloc #(.N(RX_SLOTS), .IDX_W(IDX_W)) u_alloc (
      .free_vec (rx_free),
      .idx      (pick_idx),
      .any      (pick_any)
   );

   genvar s;
   generate
      for (s = 0; s < RX_SLOTS; s++) begin : g_rx
         assign rx_cap[s] = rx_evt && pick_any && (pick_idx == IDX_W'(s));
         ts_slot #(.TIME_W(TIME_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (rx_cap[s]),
            .rel     (rx_rel[s]),
            .time_in (time_now),
            .occ     (rx_occ[s]),
            .val     (rx_val[s])
         );
      end
   endgenerate

   assign tx_cap = tx_evt && (!tx_occ || tx_rel);

   ts_slot #(.TIME_W(TIME_W)) u_tx_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (tx_cap),
      .rel     (tx_rel),
      .time_in (time_now),
      .occ     (tx_occ),
      .val     (tx_val)
   );

   ts_regfile #(
      .TIME_W   (TIME_W),
      .REG_W    (REG_W),
      .RX_SLOTS (RX_SLOTS),
      .ADDR_W   (ADDR_W),
      .RD_PIPE  (RD_PIPE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rx_occ  (rx_occ),
      .rx_val  (rx_val),
      .tx_occ  (tx_occ),
      .tx_val  (tx_val),
      .rd_data (rd_data),
      .irq_en  (irq_en),
      .rx_rel  (rx_rel),
      .tx_rel  (tx_rel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_idx_vld <= 1'b0;
         rx_idx     <= '0;
      end else begin
         rx_idx_vld <= rx_evt && pick_any;
         if (rx_evt && pick_any)
            rx_idx <= pick_idx;
      end
   end

   assign tx_irq = irq_en && tx_occ;
endmodule

// File: rtl/ts_latch_bank_chk.sv
module ts_latch_bank_chk
   import ts_latch_pkg::*;
#(
   parameter int unsigned TIME_W   = 64,
   parameter int unsigned RX_SLOTS = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            rx_evt,
   input logic                            tx_evt,
   input logic                            rd_en,
   input logic [ADDR_W-1:0]               rd_addr,
   input logic                            wr_en,
   input logic                            rx_idx_vld,
   input logic                            tx_irq,
   input logic [RX_SLOTS-1:0]             rx_occ,
   input logic [RX_SLOTS-1:0]             rx_rel,
   input logic [RX_SLOTS-1:0][TIME_W-1:0] rx_val,
   input logic                            tx_occ,
   input logic                            irq_en
);
   assert_one_more_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && rx_rel == '0 && !(&rx_occ))
      |=> ($countones(rx_occ) == $countones($past(rx_occ)) + 1));

   assert_idx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && ((~rx_occ | rx_rel) != '0)) |=> rx_idx_vld);

   assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && (&rx_occ) && rx_rel == '0) |=> (!rx_idx_vld && $stable(rx_val) && $stable(rx_occ)));

   assert_tx_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt && !tx_occ && irq_en && !wr_en) |=> tx_irq);

   genvar n;
   generate
      for (n = 0; n < RX_SLOTS; n++) begin : g_slot
         assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_occ[n] && !rx_rel[n]) |=> (rx_occ[n] && $stable(rx_val[n])));

         assert_hi_read_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(rx_hi_addr(n)) && !rx_evt) |=> !rx_occ[n]);
      end
   endgenerate
endmodule

bind ts_latch_bank ts_latch_bank_chk #(
   .TIME_W   (TIME_W),
   .RX_SLOTS (RX_SLOTS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_evt     (rx_evt),
   .tx_evt     (tx_evt),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .wr_en      (wr_en),
   .rx_idx_vld (rx_idx_vld),
   .tx_irq     (tx_irq),
   .rx_occ     (rx_occ),
   .rx_rel     (rx_rel),
   .rx_val     (rx_val),
   .tx_occ     (tx_occ),
   .irq_en     (irq_en)
);

// File: tb/sim_ts_latch_bank.sv
module sim_ts_latch_bank;
   localparam int NS = 4;
   localparam int AW = 4;
   localparam int A_CTRL = 0, A_RXST = 1, A_TXST = 2, A_TXLO = 12, A_TXHI = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = 64'h0123_4567_0000_0100;
   logic        rx_evt = 1'b0, tx_evt = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  rx_idx;
   logic        rx_idx_vld;
   logic        tx_irq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [63:0] exp_val [NS];
   logic [NS-1:0] exp_occ = '0;
   logic [63:0] tx_exp;

   always #2 clk = ~clk;
   always @(posedge clk) time_now <= time_now + 64'h0000_0001_0000_0007;

   ts_latch_bank u0 (
      .clk(clk), .rst_n(rst_n), .time_now(time_now), .rx_evt(rx_evt), .tx_evt(tx_evt),
      .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(rd_data), .rx_idx(rx_idx), .rx_idx_vld(rx_idx_vld), .tx_irq(tx_irq)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog (all reqs): actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      d = rd_data; rd_en = 1'b0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_status(input string req);
      logic [31:0] d;
      rd(A_RXST, d);
      check(req, d, {28'h0, exp_occ});
   endtask

   task automatic rel_slot(input int n);
      logic [31:0] d;
      rd(5 + 2 * n, d);
      check("R5 high word", d, exp_val[n][63:32]);
      exp_occ[n] = 1'b0;
   endtask

   task automatic chk_lo(input int n);
      logic [31:0] d;
      rd(4 + 2 * n, d);
      check("R4 held low word", d, exp_val[n][31:0]);
   endtask

   task automatic rx_ev();
      int e_idx = -1;
      logic [63:0] t;
      for (int i = NS - 1; i >= 0; i--) if (!exp_occ[i]) e_idx = i;
      t = time_now;
      rx_evt = 1'b1;
      @(negedge clk);
      rx_evt = 1'b0;
      if (e_idx < 0) begin
         check("R6 dropped flag", rx_idx_vld, 0);
      end else begin
         check("R3 valid flag", rx_idx_vld, 1);
         check("R2 lowest free idx", rx_idx, e_idx);
         exp_occ[e_idx] = 1'b1;
         exp_val[e_idx] = t;
      end
   endtask

   initial begin
      logic [31:0] d;
      logic [63:0] t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", tx_irq, 0);
      check("R1 idx_vld", rx_idx_vld, 0);
      rd(A_CTRL, d); check("R1 ctrl", d, 0);
      rd(A_RXST, d); check("R1 rx status", d, 0);
      rd(A_TXST, d); check("R1 tx status", d, 0);

      // sweep every occupancy pattern before one more event
      for (int pat = 0; pat < 16; pat++) begin
         for (int n = 0; n < NS; n++) if (exp_occ[n]) rel_slot(n);
         chk_status("R5 drained");
         for (int k = 0; k < NS; k++) rx_ev();
         chk_status("R2 all locked");
         for (int n = 0; n < NS; n++) if (!pat[n]) rel_slot(n);
         rx_ev();
         chk_status("R6/R2 status after event");
         for (int n = 0; n < NS; n++) if (exp_occ[n]) chk_lo(n);
         chk_status("R5 low read keeps lock");
         check("R3 single pulse", rx_idx_vld, 0);
      end

      // R7: release of slot 2 together with a new event
      for (int n = 0; n < NS; n++) if (!exp_occ[n]) rx_ev();
      t = time_now;
      rd_en = 1'b1; rd_addr = AW'(9); rx_evt = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; rx_evt = 1'b0;
      check("R7 old high word", rd_data, exp_val[2][63:32]);
      check("R7 valid", rx_idx_vld, 1);
      check("R7 idx", rx_idx, 2);
      exp_val[2] = t;
      chk_status("R7 status");
      chk_lo(2);
      rel_slot(2);

      // transmit slot and interrupt
      wr(A_CTRL, 0);
      rd(A_CTRL, d); check("R10 ctrl write", d, 0);
      tx_exp = time_now; tx_evt = 1'b1;
      @(negedge clk); tx_evt = 1'b0;
      check("R9 irq masked", tx_irq, 0);
      rd(A_TXST, d); check("R8 tx locked", d, 1);
      wr(A_CTRL, 1);
      check("R9 irq on enable", tx_irq, 1);
      rd(A_CTRL, d); check("R10 ctrl readback", d, 1);
      tx_evt = 1'b1;
      @(negedge clk); tx_evt = 1'b0;
      rd(A_TXLO, d); check("R8 tx low held", d, tx_exp[31:0]);
      check("R9 irq holds", tx_irq, 1);
      rd(A_TXST, d); check("R8 low read keeps lock", d, 1);
      rd(A_TXHI, d); check("R8 tx high", d, tx_exp[63:32]);
      check("R9 irq cleared", tx_irq, 0);
      rd(A_TXST, d); check("R8 tx freed", d, 0);
      tx_exp = time_now; tx_evt = 1'b1;
      @(negedge clk); tx_evt = 1'b0;
      check("R9 irq on capture", tx_irq, 1);
      rd(A_TXLO, d); check("R8 new tx low", d, tx_exp[31:0]);
      rd(A_TXHI, d); check("R8 new tx high", d, tx_exp[63:32]);

      summary();
      $finish;
   end
endmodule